// File: doc/BRIEF.md
# SPI Register-Bank Slave with Block/Subblock Addressing

This block is an SPI mode-0 slave that lets an external host read and write 32-bit registers held in a small internal store. Each register is addressed in three parts: a 3-bit block number, a 4-bit subblock number and an 8-bit register number. Only a sparse set of block/subblock pairs exists. An access to any other pair is turned away, and a sticky error flag records that it happened.

A frame opens when chip select goes low. The first byte is a command byte that packs the block, the direction and the subblock. The second byte is the register number. A write then carries four data bytes. A read carries two dummy bytes, after which the slave shifts out four data bytes. Data is big-endian in both directions. The SPI pins are synchronised into the system clock domain, so SCLK must run well below the system clock.

Top module: `spi_regbank`

## Requirements
- R1: SPI mode 0 is used, with chip select active low. MOSI is sampled on rising SCLK edges. MISO changes only after falling SCLK edges and holds steady through every rising edge.
- R2: Command byte: bits [7:5] are the block, bit 4 is the direction (1 = write, 0 = read), and bits [3:0] are the subblock.
- R3: The second byte is the register number. Its low log2(REGS_PER_SUB) bits pick one of REGS_PER_SUB registers per subblock (4 by default, so register numbers 0x05 and 0x01 name the same word). The upper bits are ignored.
- R4: A write sends four data bytes after the register byte, most significant first. The word is stored when the last bit of the fourth data byte is sampled.
- R5: A read sends two dummy bytes after the register byte. The addressed word is loaded at the falling edge that ends the second dummy byte, and it is then returned in the next four bytes, most significant bit first.
- R6: These pairs are valid: block 1 with subblocks 0–4 and 6; blocks 2 and 7 with subblock 0; blocks 3, 4 and 5 with subblocks 0 and 1. Every other block/subblock pair is invalid.
- R7: A write to an invalid pair changes no stored register and sets the error flag.
- R8: A read from an invalid pair returns 0xFFFFFFFF and sets the error flag.
- R9: Once set, the error flag stays set until reset.
- R10: Raising chip select aborts a partial frame. A write cut short stores nothing and raises no error, and the next frame begins with a command byte.
- R11: After reset every stored register reads 0, MISO is 0 and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| err_flag | output | 1 | Sticky flag for accesses to invalid addresses |

## Verification
In one frame, the address check and the data path act on the same edge. On the rising edge that completes a write, the store update and the error decision both depend on the same command byte. On the falling edge after the second dummy byte of a read, the stored word competes with the all-ones substitute for the shift register. The bench provokes both cases in three ways: it writes to an invalid pair and reads back the neighbouring valid words, it sweeps every invalid pair with reads, and it aborts a write halfway through a frame. A behavioural model built on an associative array predicts every MISO bit, and each bit is also checked for stability across the rising SCLK edge.

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int REGS_PER_SUB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic err_flag
);
  localparam int NSLOT = 14;
  localparam int DEPTH = NSLOT * REGS_PER_SUB;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = $clog2(REGS_PER_SUB);

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic [2:0] bit_cnt;
  logic [3:0] byte_cnt;
  logic [7:0] cmd;
  logic [IW-1:0] regn;
  logic [30:0] sh_in;
  logic [31:0] sh_out;
  logic rd_load;
  logic [31:0] store [DEPTH];

  function automatic logic [4:0] slot_of(input logic [2:0] b, input logic [3:0] s);
    case (b)
      3'd1: if (s <= 4'd4) return {1'b1, s};
            else if (s == 4'd6) return 5'b1_0101;
      3'd2: if (s == 4'd0) return 5'b1_0110;
      3'd3: if (s <= 4'd1) return {1'b1, 4'd7 + s};
      3'd4: if (s <= 4'd1) return {1'b1, 4'd9 + s};
      3'd5: if (s <= 4'd1) return {1'b1, 4'd11 + s};
      3'd7: if (s == 4'd0) return 5'b1_1101;
      default: ;
    endcase
    return 5'b0;
  endfunction

  wire        rise     = sclk_q[1] & ~sclk_q[2];
  wire        fall     = ~sclk_q[1] & sclk_q[2];
  wire        cs_act   = ~cs_q[1];
  wire [7:0]  byte_now = {sh_in[6:0], mosi_q[1]};
  wire [31:0] word_now = {sh_in, mosi_q[1]};
  wire        is_wr    = cmd[4];
  wire [4:0]  slot_v   = slot_of(cmd[7:5], cmd[3:0]);
  wire        valid    = slot_v[4];
  wire [AW-1:0] widx   = AW'(int'(slot_v[3:0]) * REGS_PER_SUB + int'(regn));
  wire        last_bit = rise & cs_act & (bit_cnt == 3'd7);
  wire        wr_commit = last_bit & (byte_cnt == 4'd5) & is_wr;
  wire        rd_fetch  = last_bit & (byte_cnt == 4'd3) & ~is_wr;

  assign miso = sh_out[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      cmd      <= '0;
      regn     <= '0;
      sh_in    <= '0;
      sh_out   <= '0;
      rd_load  <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      sh_out   <= '0;
      rd_load  <= 1'b0;
    end else if (rise) begin
      sh_in   <= word_now[30:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (byte_cnt != 4'd8) byte_cnt <= byte_cnt + 4'd1;
        if (byte_cnt == 4'd0) cmd  <= byte_now;
        if (byte_cnt == 4'd1) regn <= byte_now[IW-1:0];
      end
      if (rd_fetch) rd_load <= 1'b1;
    end else if (fall) begin
      if (rd_load) begin
        sh_out  <= valid ? store[widx] : '1;
        rd_load <= 1'b0;
      end else if (!is_wr && byte_cnt >= 4'd4) begin
        sh_out <= {sh_out[30:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (wr_commit && valid) begin
      store[widx] <= word_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else if ((wr_commit || rd_fetch) && !valid) err_flag <= 1'b1;
  end

  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cs_act) |=> $stable(miso)); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (byte_cnt == 4'd0 && bit_cnt == 3'd0 && !rd_load && !miso)); // R10
  AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cs_act && rd_load && !valid) |=> (sh_out == 32'hFFFF_FFFF)); // R8
  AST_BAD_ACCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_commit || rd_fetch) && !valid) |=> err_flag); // R7
  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= 4'd8); // R5
endmodule

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  localparam int H = 5;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, err_flag;
  int checks = 0, errors = 0;
  logic [31:0] model [int];
  bit model_err = 0;

  always #10 clk = ~clk;

  spi_regbank uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                   .mosi(mosi), .miso(miso), .err_flag(err_flag));

  function automatic bit ok_pair(int b, int s);
    if (b == 1) return (s <= 4) || (s == 6);
    if (b == 2 || b == 7) return s == 0;
    if (b >= 3 && b <= 5) return s <= 1;
    return 0;
  endfunction

  function automatic int key(int b, int s, int r);
    return b * 64 + s * 4 + (r % 4);
  endfunction

  function automatic logic [31:0] expect_rd(int b, int s, int r);
    if (!ok_pair(b, s)) return 32'hFFFF_FFFF;
    if (model.exists(key(b, s, r))) return model[key(b, s, r)];
    return 32'h0;
  endfunction

  task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r, input bit chk_hold);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (H) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (H - 1) @(negedge clk);
      if (chk_hold) check(miso == r[i], "R1 miso stable while sclk high", miso, r[i]);
      @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic do_write(input int b, input int s, input int r, input logic [31:0] v);
    logic [7:0] rx;
    frame_open();
    xbyte({3'(b), 1'b1, 4'(s)}, rx, 0);
    xbyte(8'(r), rx, 0);
    for (int k = 3; k >= 0; k--) xbyte(v[k*8 +: 8], rx, 0);
    frame_close();
    if (ok_pair(b, s)) model[key(b, s, r)] = v;
    else model_err = 1;
  endtask

  task automatic do_read(input int b, input int s, input int r, output logic [31:0] got);
    logic [7:0] rx;
    frame_open();
    xbyte({3'(b), 1'b0, 4'(s)}, rx, 0);
    xbyte(8'(r), rx, 0);
    xbyte(8'h00, rx, 0);
    xbyte(8'h00, rx, 0);
    for (int k = 3; k >= 0; k--) begin
      xbyte(8'h00, rx, 1);
      got[k*8 +: 8] = rx;
    end
    frame_close();
    if (!ok_pair(b, s)) model_err = 1;
  endtask

  task automatic read_check(input int b, input int s, input int r, input string req);
    logic [31:0] got, exp;
    exp = expect_rd(b, s, r);
    do_read(b, s, r, got);
    check(got === exp, req, got, exp);
    check(err_flag === model_err, {req, " error flag"}, {31'b0, err_flag}, {31'b0, model_err});
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model.delete();
    model_err = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    apply_reset();
    // R11 reset state
    check(miso === 1'b0, "R11 miso after reset", {31'b0, miso}, 32'h0);
    check(err_flag === 1'b0, "R11 error flag after reset", {31'b0, err_flag}, 32'h0);
    read_check(1, 6, 8'h19, "R11 store reads zero");

    // R2 R4 R5 R6: every valid pair written and read back
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 16; s++)
        if (ok_pair(b, s)) do_write(b, s, b + s, 32'hA500_0000 ^ (b << 20) ^ (s << 8) ^ 32'h81);
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 16; s++)
        if (ok_pair(b, s)) read_check(b, s, b + s, "R6 valid pair readback R4 R5");

    // R3 register aliasing in the low bits of the register number
    do_write(5, 1, 8'h05, 32'h1234_5678);
    read_check(5, 1, 8'h01, "R3 alias 0x05/0x01");
    read_check(5, 1, 8'h02, "R3 other register unaffected");

    // R10 aborted write stores nothing and raises no error
    frame_open();
    xbyte({3'd1, 1'b1, 4'd0}, rx, 0);
    xbyte(8'h00, rx, 0);
    xbyte(8'hDE, rx, 0);
    xbyte(8'hAD, rx, 0);
    frame_close();
    read_check(1, 0, 8'h00, "R10 aborted write");
    check(err_flag === 1'b0, "R10 no error on abort", {31'b0, err_flag}, 32'h0);

    // R7 invalid write dropped, neighbours unchanged
    do_write(2, 1, 8'h00, 32'hCAFE_F00D);
    read_check(3, 0, 8'h00, "R7 neighbour block3 sub0 unchanged");
    read_check(2, 0, 8'h00, "R7 block2 sub0 unchanged");
    check(err_flag === 1'b1, "R7 error flag after bad write", {31'b0, err_flag}, 32'h1);

    // R9 flag stays set across valid traffic
    do_write(7, 0, 8'h10, 32'h0000_0001);
    read_check(7, 0, 8'h10, "R9 flag persists");

    // R11 reset clears the store, R8 invalid read sweep
    apply_reset();
    read_check(4, 1, 8'h00, "R11 store cleared by reset");
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 16; s++)
        if (!ok_pair(b, s)) read_check(b, s, 8'h00, "R8 invalid read all ones R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule